// File: doc/BRIEF.md
# Serial Link Control Word Codec

This block sits on one serial port of a crosspoint switch and handles the fixed-format words that cross that link. Each word arrives and leaves as a parallel 23-bit bus. Bits [22:21] hold a word-type field, bits [20:16] hold a command field and bits [15:0] hold a data field. A valid strobe qualifies each word.

On the receive side every qualified word is sorted into one of seven classes, and its type and data are passed on. The command that carries the delay-enable / cell-clock-in setting is latched into an output register. Command codes that match no defined pattern are dropped and noted in a sticky flag. Idle words are compared against an expected pattern under a programmable mask. A mismatch gives a one-cycle link-error pulse and advances a saturating error counter.

On the transmit side a queued word is forwarded unchanged, or with its data replaced by the default fill pattern. When nothing is queued, an idle word is sent instead, in packet mode always and in cell mode only while force-idle is set. On the switch side, idle words carry the port's live output-connection bitmap.

Top module: `link_word_codec`

## Requirements
- R1: A received word is classified one register stage after its strobe. rx_out_class encodes ALIGN=0, FLOW=1, ACK=2, IDLE=3, XCVR=4, SWITCH=5, PCARD=6. Any command with bits [4:3]=00, other than 00111, is classified by its type field: 00 gives ALIGN, 01 and 10 give FLOW, 11 gives ACK.
- R2: Command 00111 gives IDLE. Commands 01xx0, 10xx0 and 11xx0 give XCVR, SWITCH and PCARD.
- R3: For each accepted word, rx_out_type and rx_out_data repeat the word's type field and data field, and rx_out_valid is high for one cycle.
- R4: Command 01000 latches data bits [3:0] into dlycck_val. Other words, including other XCVR commands, leave dlycck_val unchanged.
- R5: A command with bits [4:3] not equal to 00 and bit 0 equal to 1 is unknown. No rx_out_valid is produced for it, and unknown_cmd is set. unknown_cmd stays set until clr_err.
- R6: A received idle word whose data differs from 0xAAAA in any bit where idle_mask is 1 raises link_err for exactly one cycle. Differences in bits where the mask is 0 are ignored.
- R7: idle_err_cnt counts link errors and saturates at 255. clr_err returns it to 0. If clr_err coincides with a new error, the count becomes 1.
- R8: A queued transmit word appears on tx_out_word one cycle later. When tx_in_nodata is set, its data field is replaced with 0xAAAA.
- R9: With no word queued, an idle word (type 00, command 00111) is sent if packet_mode or force_idle is set. Otherwise tx_out_valid is low.
- R10: On the switch side, the data field of an idle word is the connection bitmap, with conn_map[0] (port 0) placed in bit 15 and conn_map[15] in bit 0.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received word strobe |
| rx_word | input | 23 | Received word {type, command, data} |
| idle_mask | input | 16 | Bits of idle data that are checked |
| clr_err | input | 1 | Clear pulse for error counter and unknown flag |
| rx_out_valid | output | 1 | Accepted word output strobe |
| rx_out_class | output | 3 | Word class code |
| rx_out_type | output | 2 | Type field of accepted word |
| rx_out_data | output | 16 | Data field of accepted word |
| dlycck_val | output | 4 | Latched delay-enable / cell-clock-in value |
| unknown_cmd | output | 1 | Sticky unknown command flag |
| link_err | output | 1 | One-cycle idle mismatch pulse |
| idle_err_cnt | output | 8 | Saturating idle error count |
| tx_in_valid | input | 1 | Queued transmit word present |
| tx_in_word | input | 23 | Queued transmit word |
| tx_in_nodata | input | 1 | Replace data with default fill |
| packet_mode | input | 1 | Packet mode: idles fill gaps |
| force_idle | input | 1 | Cell mode: send idles in gaps |
| conn_map | input | 16 | Current output connections, bit i = port i |
| tx_out_valid | output | 1 | Transmit word present |
| tx_out_word | output | 23 | Transmit word |

## Verification
Two events can fall in the same clock: the error clear pulse and a newly detected idle mismatch, both acting on the error counter. The unknown-command flag has the same kind of collision between its clear and a new unknown word. The bench drives clr_err in the same cycle that a corrupted idle word is strobed. It then expects the count to read 1, not 0 and not the old count plus one. It also checks that a saturated count of 255 is the value being cleared.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
  localparam int TYPE_W = 2;
  localparam int CMD_W  = 5;

  localparam logic [CMD_W-1:0] CMD_IDLE   = 5'b00111;
  localparam logic [CMD_W-1:0] CMD_DLYCCK = 5'b01000;
  localparam logic [CMD_W-1:0] CMD_ALIGN  = 5'b00000;

  typedef enum logic [2:0] {
    CL_ALIGN  = 3'd0,
    CL_FLOW   = 3'd1,
    CL_ACK    = 3'd2,
    CL_IDLE   = 3'd3,
    CL_XCVR   = 3'd4,
    CL_SWITCH = 3'd5,
    CL_PCARD  = 3'd6
  } word_class_e;
endpackage

// File: rtl/lwc_rx_classify.sv
module lwc_rx_classify
  import lwc_pkg::*;
(
  input  logic [TYPE_W-1:0] typ,
  input  logic [CMD_W-1:0]  cmd,
  output word_class_e       cls,
  output logic              unknown,
  output logic              is_dlycck
);
  always_comb begin
    cls       = CL_ALIGN;
    unknown   = 1'b0;
    is_dlycck = (cmd == CMD_DLYCCK);
    if (cmd == CMD_IDLE) begin
      cls = CL_IDLE;
    end else if (cmd[4:3] == 2'b00) begin
      case (typ)
        2'b00:        cls = CL_ALIGN;
        2'b01, 2'b10: cls = CL_FLOW;
        default:      cls = CL_ACK;
      endcase
    end else if (cmd[0]) begin
      unknown = 1'b1;
    end else begin
      case (cmd[4:3])
        2'b01:   cls = CL_XCVR;
        2'b10:   cls = CL_SWITCH;
        default: cls = CL_PCARD;
      endcase
    end
  end
endmodule

// File: rtl/lwc_idle_check.sv
module lwc_idle_check #(
  parameter int              DATA_W   = 16,
  parameter int              CNT_W    = 8,
  parameter logic [DATA_W-1:0] EXP_PAT = 16'hAAAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_en,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  input  logic              clr,
  output logic              err_pulse,
  output logic [CNT_W-1:0]  err_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic hit;
  assign hit = chk_en && (|((data ^ EXP_PAT) & mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_cnt   <= '0;
    end else begin
      err_pulse <= hit;
      if (clr)
        err_cnt <= hit ? CNT_ONE : '0;
      else if (hit && err_cnt != CNT_MAX)
        err_cnt <= err_cnt + CNT_ONE;
    end
  end
endmodule

// File: rtl/lwc_tx_mux.sv
module lwc_tx_mux
  import lwc_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter bit                SWITCH_SIDE = 1'b1,
  parameter logic [DATA_W-1:0] FILL_PAT    = 16'hAAAA
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [DATA_W+6:0]       in_word,
  input  logic                    in_nodata,
  input  logic                    packet_mode,
  input  logic                    force_idle,
  input  logic [DATA_W-1:0]       conn_map,
  output logic                    out_valid,
  output logic [DATA_W+6:0]       out_word
);
  localparam int WORD_W = DATA_W + TYPE_W + CMD_W;

  logic [DATA_W-1:0] idle_data;
  logic [WORD_W-1:0] idle_word;
  logic [WORD_W-1:0] fwd_word;

  generate
    if (SWITCH_SIDE) begin : g_sw
      for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign idle_data[DATA_W-1-i] = conn_map[i];
      end
    end else begin : g_card
      assign idle_data = FILL_PAT;
    end
  endgenerate

  assign idle_word = {2'b00, CMD_IDLE, idle_data};
  assign fwd_word  = in_nodata ? {in_word[WORD_W-1:DATA_W], FILL_PAT} : in_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (in_valid) begin
      out_valid <= 1'b1;
      out_word  <= fwd_word;
    end else if (packet_mode || force_idle) begin
      out_valid <= 1'b1;
      out_word  <= idle_word;
    end else begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end
  end
endmodule

// File: rtl/link_word_codec.sv
module link_word_codec
  import lwc_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter int                CNT_W       = 8,
  parameter bit                SWITCH_SIDE = 1'b1,
  parameter logic [DATA_W-1:0] FILL_PAT    = 16'hAAAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W+6:0] rx_word,
  input  logic [DATA_W-1:0] idle_mask,
  input  logic              clr_err,
  output logic              rx_out_valid,
  output logic [2:0]        rx_out_class,
  output logic [1:0]        rx_out_type,
  output logic [DATA_W-1:0] rx_out_data,
  output logic [3:0]        dlycck_val,
  output logic              unknown_cmd,
  output logic              link_err,
  output logic [CNT_W-1:0]  idle_err_cnt,
  input  logic              tx_in_valid,
  input  logic [DATA_W+6:0] tx_in_word,
  input  logic              tx_in_nodata,
  input  logic              packet_mode,
  input  logic              force_idle,
  input  logic [DATA_W-1:0] conn_map,
  output logic              tx_out_valid,
  output logic [DATA_W+6:0] tx_out_word
);
  localparam int DATA_LO = 0;
  localparam int CMD_LO  = DATA_W;
  localparam int TYPE_LO = DATA_W + CMD_W;

  logic [TYPE_W-1:0] f_type;
  logic [CMD_W-1:0]  f_cmd;
  logic [DATA_W-1:0] f_data;
  word_class_e       cls;
  logic              unk, is_dly;

  assign f_type = rx_word[TYPE_LO +: TYPE_W];
  assign f_cmd  = rx_word[CMD_LO +: CMD_W];
  assign f_data = rx_word[DATA_LO +: DATA_W];

  lwc_rx_classify u_cls (
    .typ       (f_type),
    .cmd       (f_cmd),
    .cls       (cls),
    .unknown   (unk),
    .is_dlycck (is_dly)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_out_valid <= 1'b0;
      rx_out_class <= 3'd0;
      rx_out_type  <= 2'd0;
      rx_out_data  <= '0;
      dlycck_val   <= 4'd0;
      unknown_cmd  <= 1'b0;
    end else begin
      rx_out_valid <= rx_valid && !unk;
      if (rx_valid && !unk) begin
        rx_out_class <= cls;
        rx_out_type  <= f_type;
        rx_out_data  <= f_data;
      end
      if (rx_valid && is_dly)
        dlycck_val <= f_data[3:0];
      if (rx_valid && unk)
        unknown_cmd <= 1'b1;
      else if (clr_err)
        unknown_cmd <= 1'b0;
    end
  end

  lwc_idle_check #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .EXP_PAT (FILL_PAT)
  ) u_idle (
    .clk       (clk),
    .rst       (rst),
    .chk_en    (rx_valid && (f_cmd == CMD_IDLE)),
    .data      (f_data),
    .mask      (idle_mask),
    .clr       (clr_err),
    .err_pulse (link_err),
    .err_cnt   (idle_err_cnt)
  );

  lwc_tx_mux #(
    .DATA_W      (DATA_W),
    .SWITCH_SIDE (SWITCH_SIDE),
    .FILL_PAT    (FILL_PAT)
  ) u_tx (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (tx_in_valid),
    .in_word     (tx_in_word),
    .in_nodata   (tx_in_nodata),
    .packet_mode (packet_mode),
    .force_idle  (force_idle),
    .conn_map    (conn_map),
    .out_valid   (tx_out_valid),
    .out_word    (tx_out_word)
  );
endmodule

// File: rtl/lwc_checker.sv
module lwc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_err,
  input logic             rx_out_valid,
  input logic [2:0]       rx_out_class,
  input logic             link_err,
  input logic             unknown_cmd,
  input logic [CNT_W-1:0] idle_err_cnt,
  input logic             tx_in_valid,
  input logic             packet_mode,
  input logic             force_idle,
  input logic             tx_out_valid
);
  assert_sticky_unknown_R5: assert property (@(posedge clk) disable iff (rst)
    (unknown_cmd && !clr_err) |=> unknown_cmd);

  assert_err_is_idle_R6: assert property (@(posedge clk) disable iff (rst)
    link_err |-> (rx_out_valid && rx_out_class == 3'd3));

  assert_cnt_monotone_R7: assert property (@(posedge clk) disable iff (rst)
    !clr_err |=> (idle_err_cnt >= $past(idle_err_cnt)));

  assert_cnt_rises_R7: assert property (@(posedge clk) disable iff (rst)
    (link_err && !$past(clr_err) && $past(idle_err_cnt) != {CNT_W{1'b1}})
      |-> (idle_err_cnt == $past(idle_err_cnt) + 1'b1));

  assert_fwd_R8: assert property (@(posedge clk) disable iff (rst)
    tx_in_valid |=> tx_out_valid);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!tx_in_valid && !packet_mode && !force_idle) |=> !tx_out_valid);

  assert_class_range_R1: assert property (@(posedge clk) disable iff (rst)
    rx_out_valid |-> (rx_out_class <= 3'd6));
endmodule

bind link_word_codec lwc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .clr_err      (clr_err),
  .rx_out_valid (rx_out_valid),
  .rx_out_class (rx_out_class),
  .link_err     (link_err),
  .unknown_cmd  (unknown_cmd),
  .idle_err_cnt (idle_err_cnt),
  .tx_in_valid  (tx_in_valid),
  .packet_mode  (packet_mode),
  .force_idle   (force_idle),
  .tx_out_valid (tx_out_valid)
);

// File: tb/sim_link_word_codec.sv
module sim_link_word_codec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [22:0] rx_word = '0;
  logic [15:0] idle_mask = 16'hFFFF;
  logic        clr_err = 1'b0;
  logic        rx_out_valid;
  logic [2:0]  rx_out_class;
  logic [1:0]  rx_out_type;
  logic [15:0] rx_out_data;
  logic [3:0]  dlycck_val;
  logic        unknown_cmd;
  logic        link_err;
  logic [7:0]  idle_err_cnt;
  logic        tx_in_valid = 1'b0;
  logic [22:0] tx_in_word = '0;
  logic        tx_in_nodata = 1'b0;
  logic        packet_mode = 1'b0;
  logic        force_idle = 1'b0;
  logic [15:0] conn_map = '0;
  logic        tx_out_valid;
  logic [22:0] tx_out_word;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  link_word_codec u0 (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] mk(input logic [1:0] t, input logic [4:0] c, input logic [15:0] d);
    return {t, c, d};
  endfunction

  task automatic rx_send(input logic [22:0] w);
    @(negedge clk); rx_valid = 1'b1; rx_word = w;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(rx_out_valid, 0, "R11 rx_out_valid");
    chk(dlycck_val, 0, "R11 dlycck_val");
    chk(unknown_cmd, 0, "R11 unknown_cmd");
    chk(idle_err_cnt, 0, "R11 idle_err_cnt");
    chk(tx_out_valid, 0, "R11 tx_out_valid");
  endtask

  task automatic t_link_classes();
    rx_send(mk(2'b00, 5'b00000, 16'h1111)); chk(rx_out_class, 0, "R1 align");
    rx_send(mk(2'b01, 5'b00000, 16'h2222)); chk(rx_out_class, 1, "R1 flow 01");
    rx_send(mk(2'b10, 5'b00010, 16'h3333)); chk(rx_out_class, 1, "R1 flow 10");
    rx_send(mk(2'b11, 5'b00000, 16'h4444)); chk(rx_out_class, 2, "R1 ack");
    chk(rx_out_data, 16'h4444, "R3 data");
    chk(rx_out_type, 2'b11, "R3 type");
    chk(rx_out_valid, 1, "R3 valid");
    @(negedge clk); chk(rx_out_valid, 0, "R3 single pulse");
  endtask

  task automatic t_cmd_classes();
    rx_send(mk(2'b11, 5'b00111, 16'hAAAA)); chk(rx_out_class, 3, "R2 idle");
    rx_send(mk(2'b00, 5'b01110, 16'h0005)); chk(rx_out_class, 4, "R2 xcvr");
    rx_send(mk(2'b00, 5'b10100, 16'h0006)); chk(rx_out_class, 5, "R2 switch");
    rx_send(mk(2'b00, 5'b11010, 16'h0007)); chk(rx_out_class, 6, "R2 pcard");
  endtask

  task automatic t_dlycck();
    rx_send(mk(2'b00, 5'b01000, 16'hF0C9)); chk(dlycck_val, 4'h9, "R4 latch");
    rx_send(mk(2'b00, 5'b01010, 16'h0003)); chk(dlycck_val, 4'h9, "R4 other xcvr no effect");
  endtask

  task automatic t_unknown();
    rx_send(mk(2'b00, 5'b01001, 16'h1234));
    chk(rx_out_valid, 0, "R5 discarded");
    chk(unknown_cmd, 1, "R5 flag set");
    rx_send(mk(2'b00, 5'b00000, 16'h0000));
    chk(unknown_cmd, 1, "R5 sticky");
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    chk(unknown_cmd, 0, "R5 cleared");
  endtask

  task automatic t_idle_mask();
    idle_mask = 16'hFFFF;
    rx_send(mk(2'b00, 5'b00111, 16'hAAAA)); chk(link_err, 0, "R6 good idle");
    rx_send(mk(2'b00, 5'b00111, 16'hAAAB)); chk(link_err, 1, "R6 bad idle");
    @(negedge clk); chk(link_err, 0, "R6 one cycle");
    chk(idle_err_cnt, 1, "R7 count one");
    idle_mask = 16'hFFFE;
    rx_send(mk(2'b00, 5'b00111, 16'hAAAB)); chk(link_err, 0, "R6 masked bit ignored");
    chk(idle_err_cnt, 1, "R6 masked no count");
  endtask

  task automatic t_saturate();
    idle_mask = 16'hFFFF;
    @(negedge clk); rx_valid = 1'b1; rx_word = mk(2'b00, 5'b00111, 16'h0000);
    for (int i = 0; i < 260; i++) @(negedge clk);
    rx_valid = 1'b0;
    chk(idle_err_cnt, 255, "R7 saturate");
    @(negedge clk); clr_err = 1'b1; rx_valid = 1'b1;
    @(negedge clk); clr_err = 1'b0; rx_valid = 1'b0;
    chk(idle_err_cnt, 1, "R7 clear with error");
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    chk(idle_err_cnt, 0, "R7 clear");
  endtask

  task automatic t_tx();
    packet_mode = 1'b0; force_idle = 1'b0; conn_map = 16'h0001;
    @(negedge clk); chk(tx_out_valid, 0, "R9 cell no idle");
    tx_in_valid = 1'b1; tx_in_word = mk(2'b01, 5'b10010, 16'h5A5A);
    @(negedge clk); chk(tx_out_word, mk(2'b01, 5'b10010, 16'h5A5A), "R8 forward");
    tx_in_nodata = 1'b1; tx_in_word = mk(2'b11, 5'b10000, 16'h1234);
    @(negedge clk); chk(tx_out_word, mk(2'b11, 5'b10000, 16'hAAAA), "R8 fill");
    tx_in_valid = 1'b0; tx_in_nodata = 1'b0; force_idle = 1'b1;
    @(negedge clk); chk(tx_out_word, mk(2'b00, 5'b00111, 16'h8000), "R10 port0 bit15");
    chk(tx_out_valid, 1, "R9 force idle");
    force_idle = 1'b0; packet_mode = 1'b1; conn_map = 16'h8003;
    @(negedge clk); chk(tx_out_word, mk(2'b00, 5'b00111, 16'hC001), "R10 map");
    chk(tx_out_valid, 1, "R9 packet idle");
    packet_mode = 1'b0;
    @(negedge clk); chk(tx_out_valid, 0, "R9 quiet");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_link_classes();
    t_cmd_classes();
    t_dlycck();
    t_unknown();
    t_idle_mask();
    t_saturate();
    t_tx();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule